// File: doc/BRIEF.md
# Event Status and Interrupt Register Group

This block watches a vector of event flags, such as threshold-crossing or clipping indicators from a converter channel bank. It shows those flags to software in two ways. The live view is a read-only copy of the flags as sampled at the last clock edge. The sticky view keeps each flag set once it has been seen, until software clears it by writing a 1 to that bit.

Each flag also has an interrupt enable bit and a mode bit. In level mode, an enabled flag requests service for as long as its sticky bit is set. In edge mode, an enabled flag requests service only after its event goes from 0 to 1. That request stays pending until software clears the bit through the same write-1-to-clear action on the sticky register. A single interrupt line is the OR of every enabled request.

Software reaches the four registers through one plain word port. The 2-bit word address picks the register. Reads are combinational from the stored state, and a write takes effect at the clock edge where the write strobe is high.

Top module: `stsirq_top`

## Requirements
- R1: The word address selects the register: 0 is the live view, 1 is the sticky view, 2 is the interrupt enable mask and 3 is the mode select, where a mode bit of 0 means level and 1 means edge.
- R2: A read of address 0 returns the event vector sampled at the most recent clock edge. A write to address 0 changes no state.
- R3: A sticky bit becomes 1 at every clock edge where its event bit is 1, and it stays 1 until it is cleared.
- R4: A write to address 1 clears each sticky bit whose data bit is 1. Data bits of 0 leave the corresponding sticky bits unchanged.
- R5: If an event bit is 1 in the same cycle as a clear write to that bit, the bit ends up set. The same holds for an edge-pending flag whose event rises in the clear cycle.
- R6: The enable mask and the mode select are plain read/write registers of the full vector width.
- R7: After reset, the sticky, enable and mode registers, the live view and the interrupt line are all 0.
- R8: In level mode, an enabled bit requests an interrupt whenever its sticky bit is 1.
- R9: In edge mode, a bit's pending flag is set when its event is 1 and its previous sample was 0. A write-1-to-clear on address 1 clears the flag. An enabled bit requests an interrupt while the flag is set.
- R10: The interrupt line is high exactly when at least one bit has an enabled request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | W | Live event flags, 1 = out of range |
| reg_addr | input | 2 | Word address of the register accessed |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the event vector and the register port are stable around each rising edge. They also assume that a write strobe is seen only at the edge where it is intended to act. The bench meets this by changing every input on the falling edge and dropping the write strobe right after the rising edge. It then reads back all four registers between edges, with no strobe active. The random events are made sparse so that both rising edges and held-high runs occur, which exercises edge and level requests and same-cycle set/clear collisions.

// File: rtl/stsirq_pkg.sv
// Shared definitions for the status/interrupt register group.
// Assumes a 2-bit word address space with four registers.
package stsirq_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_LIVE   = 2'd0,
        SEL_STICKY = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_MODE   = 2'd3
    } sel_e;
endpackage

// File: rtl/stsirq_sticky.sv
// Samples the event vector and keeps the sticky bits and edge-pending flags.
// Assumes clr_i is nonzero only during a write-1-to-clear cycle.
// A new event or rise in the clear cycle wins over the clear.
module stsirq_sticky #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] live_o,
    output logic [W-1:0] sticky_o,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] live_q, sticky_q, pend_q;
    logic [W-1:0] rise;

    // Rising-edge detect against the previous sample.
    always_comb rise = evt_i & ~live_q;

    // Sample the events, then set or clear the sticky bits and pending flags (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q   <= '0;
            sticky_q <= '0;
            pend_q   <= '0;
        end else begin
            live_q   <= evt_i;
            sticky_q <= (sticky_q & ~clr_i) | evt_i;
            pend_q   <= (pend_q & ~clr_i) | rise;
        end
    end

    assign live_o   = live_q;
    assign sticky_o = sticky_q;
    assign pend_o   = pend_q;

    // R3
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((sticky_q & $past(evt_i)) == $past(evt_i)));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky_q & $past(sticky_q & ~clr_i)) == $past(sticky_q & ~clr_i)));

    // R4
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~evt_i)) |=> ((sticky_q & $past(clr_i & ~evt_i)) == '0));

    // R7
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (sticky_q == '0 && pend_q == '0 && live_q == '0));
endmodule

// File: rtl/stsirq_cfg.sv
// Holds the interrupt enable mask and the per-bit edge/level mode.
// Assumes at most one write strobe is high in any cycle.
module stsirq_cfg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_mask_i,
    input  logic         wr_mode_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] mode_o
);
    logic [W-1:0] mask_q, mode_q;

    // Load the mask and mode registers from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            mode_q <= '0;
        end else begin
            if (wr_mask_i) mask_q <= wdata_i;
            if (wr_mode_i) mode_q <= wdata_i;
        end
    end

    assign mask_o = mask_q;
    assign mode_o = mode_q;

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask_i |=> (mask_q == $past(wdata_i)));

    // R6
    mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode_i |=> $stable(mode_q));
endmodule

// File: rtl/stsirq_req.sv
// Forms the per-bit interrupt requests and ORs them into one line.
// Assumes all inputs come from registers, so irq_o is glitch-free per cycle.
module stsirq_req #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sticky_i,
    input  logic [W-1:0] pend_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] mode_i,
    output logic         irq_o
);
    logic [W-1:0] req;

    // Each bit picks its level or edge source, gated by its enable.
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb req[b] = mask_i[b] & (mode_i[b] ? pend_i[b] : sticky_i[b]);
    end

    // Reduce all per-bit requests to the shared line.
    always_comb irq_o = |req;

    // R8
    level_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sticky_i & mask_i & ~mode_i)) |-> irq_o);

    // R9
    edge_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_i & mask_i & mode_i)) |-> irq_o);

    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |-> !irq_o);
endmodule

// File: rtl/stsirq_top.sv
// Status and interrupt register group for a W-bit event vector.
// Assumes a single-cycle write strobe and combinational reads.
module stsirq_top
    import stsirq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     evt_i,
    input  logic [SEL_W-1:0] reg_addr,
    input  logic             reg_wr,
    input  logic [W-1:0]     reg_wdata,
    output logic [W-1:0]     reg_rdata,
    output logic             irq_o
);
    sel_e         sel;
    logic [W-1:0] clr, live, sticky, pend, mask, mode;
    logic         wr_mask, wr_mode;

    // Decode the word address and write strobes.
    always_comb begin
        sel     = sel_e'(reg_addr);
        clr     = (reg_wr && sel == SEL_STICKY) ? reg_wdata : '0;
        wr_mask = reg_wr && sel == SEL_MASK;
        wr_mode = reg_wr && sel == SEL_MODE;
    end

    stsirq_sticky #(.W(W)) u_sticky (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr),
        .live_o(live), .sticky_o(sticky), .pend_o(pend)
    );

    stsirq_cfg #(.W(W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_mask_i(wr_mask), .wr_mode_i(wr_mode),
        .wdata_i(reg_wdata), .mask_o(mask), .mode_o(mode)
    );

    stsirq_req #(.W(W)) u_req (
        .clk(clk), .rst_n(rst_n), .sticky_i(sticky), .pend_i(pend),
        .mask_i(mask), .mode_i(mode), .irq_o(irq_o)
    );

    // Read multiplexer over the four registers.
    always_comb begin
        unique case (sel)
            SEL_LIVE:   reg_rdata = live;
            SEL_STICKY: reg_rdata = sticky;
            SEL_MASK:   reg_rdata = mask;
            SEL_MODE:   reg_rdata = mode;
            default:    reg_rdata = '0;
        endcase
    end

    // R2
    live_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (live == $past(evt_i)));
endmodule

// File: tb/sim_stsirq_top.sv
module sim_stsirq_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt_i = '0;
    logic [1:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         irq_o;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] m_live = '0, m_sticky = '0, m_pend = '0, m_mask = '0, m_mode = '0;

    always #4 clk = ~clk;

    stsirq_top #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic model_irq();
        return |(((m_sticky & ~m_mode) | (m_pend & m_mode)) & m_mask);
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Read all four registers and the line between edges (R1).
    task automatic check_all(input string ctx);
        reg_addr = 2'd0; #1 check({"R2 live ", ctx}, reg_rdata, m_live);
        reg_addr = 2'd1; #1 check({"R3 R4 sticky ", ctx}, reg_rdata, m_sticky);
        reg_addr = 2'd2; #1 check({"R6 mask ", ctx}, reg_rdata, m_mask);
        reg_addr = 2'd3; #0.5 check({"R6 mode ", ctx}, reg_rdata, m_mode);
        check({"R10 irq ", ctx}, {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, model_irq()});
    endtask

    // One cycle: drive on the falling edge, update the model, check after the rising edge.
    task automatic step(input logic [W-1:0] evt, input logic wr, input logic [1:0] addr,
                        input logic [W-1:0] data, input string ctx);
        logic [W-1:0] clr;
        @(negedge clk);
        evt_i = evt; reg_wr = wr; reg_addr = addr; reg_wdata = data;
        clr = (wr && addr == 2'd1) ? data : '0;
        m_pend   = (m_pend & ~clr) | (evt & ~m_live);
        m_sticky = (m_sticky & ~clr) | evt;
        if (wr && addr == 2'd2) m_mask = data;
        if (wr && addr == 2'd3) m_mode = data;
        m_live = evt;
        @(posedge clk);
        #1 reg_wr = 1'b0;
        check_all(ctx);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 check_all("R7 reset");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 check_all("R7 after reset");

        // R2: writing the live address has no effect
        step('0, 1'b1, 2'd0, 32'hFFFF_FFFF, "R2 write ignored");
        // R3: event sets sticky, stays after event drops
        step(32'h0000_0011, 1'b0, 2'd0, '0, "R3 set");
        step('0, 1'b0, 2'd0, '0, "R3 hold");
        // R4: writing zeros leaves sticky bits
        step('0, 1'b1, 2'd1, 32'h0000_0000, "R4 zero write");
        step('0, 1'b1, 2'd1, 32'h0000_0001, "R4 clear one");
        // R5: event and clear in the same cycle, set wins
        step(32'h0000_0010, 1'b1, 2'd1, 32'h0000_0010, "R5 collision");
        step('0, 1'b1, 2'd1, 32'h0000_0010, "R5 cleared");
        // R8: level mode request
        step('0, 1'b1, 2'd2, 32'h8000_0001, "R6 mask");
        step(32'h0000_0001, 1'b0, 2'd0, '0, "R8 level irq");
        step(32'h0000_0001, 1'b1, 2'd1, 32'h0000_0001, "R8 held event re-sets");
        step('0, 1'b1, 2'd1, 32'h0000_0001, "R8 clear drops irq");
        // R9: edge mode, held event does not re-request after clear
        step('0, 1'b1, 2'd3, 32'h8000_0000, "R6 mode");
        step(32'h8000_0000, 1'b0, 2'd0, '0, "R9 rise");
        step(32'h8000_0000, 1'b1, 2'd1, 32'h8000_0000, "R9 clear while high");
        step(32'h8000_0000, 1'b0, 2'd0, '0, "R9 no new rise");
        step('0, 1'b0, 2'd0, '0, "R9 fall");
        step(32'h8000_0000, 1'b1, 2'd1, 32'h8000_0000, "R5 rise during clear");
        step('0, 1'b1, 2'd1, 32'hFFFF_FFFF, "R9 clear all");

        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] ev, wd;
            logic [1:0]   ad;
            logic         wr;
            ev = $urandom & $urandom & $urandom;
            wd = $urandom;
            ad = 2'($urandom);
            wr = ($urandom % 3) == 0;
            step(ev, wr, ad, wd, "R1 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule